// File: doc/BRIEF.md
# Directory Coherence Controller

This block is the home-node directory for a group of cache blocks in a multiprocessor whose memory is distributed among the processors. Every tracked block has a sharing state (uncached, shared or exclusive) and a presence vector with one bit per processor. Processors send read-miss, write-miss and write-back requests to it. For each request the controller looks up the entry and works out the new entry. It then sends directed coherence messages to the processors that hold copies. These are invalidations to sharers, a downgrade-and-supply request to an exclusive owner, or a fetch-and-invalidate that takes the block away from an owner.

The controller handles one request at a time. It issues at most one message per cycle, to the lowest-numbered pending target first. It counts one acknowledgement for every message sent. Only when every acknowledgement has arrived does it send a one-cycle response to the requester and commit the entry. The response carries the new state and presence vector, and an error flag if the request broke the protocol. The caches, the network and the data memory are outside this block.

Top module: `coh_dir_ctrl`

## Requirements
- R1: After reset every entry is uncached with an empty presence vector, `req_ready` is 1, and `msg_valid` and `rsp_valid` are 0.
- R2: A read miss (kind 0) on an uncached block sends no message. It leaves the block shared (state 1) with only the requester's bit set.
- R3: A read miss on a shared block from a processor not in the vector sends no message. The block stays shared and the requester's bit is added.
- R4: A write miss (kind 1) on an uncached block sends no message. It leaves the block exclusive (state 2) with only the writer's bit set.
- R5: A write miss on a shared block from a non-sharer sends one invalidate (message code 0) to each sharer, one per cycle, in ascending processor index. The block then becomes exclusive with only the writer's bit set.
- R6: A read miss on an exclusive block from a non-owner sends exactly one downgrade (code 1) to the owner. The block becomes shared with both the owner's and the requester's bits set.
- R7: A write miss on an exclusive block from a non-owner sends exactly one take-away (code 2) to the owner. The block stays exclusive with only the new writer's bit set.
- R8: A write-back (kind 2) from the owner of an exclusive block sends no message. It leaves the block uncached (state 0) with all bits clear.
- R9: Two cases are protocol errors: a read or write miss from a processor whose bit is already set, and a write-back from anything other than the exclusive owner. On an error the response has `rsp_err` = 1, no message is sent, and the entry is unchanged. The response reports the entry as it was.
- R10: The response waits until every message has been sent and acknowledged. It lasts exactly one cycle and goes to the requester. `req_ready` is 0 from the cycle after acceptance through the response cycle.
- R11: An acknowledgement that arrives in the same cycle as a message is issued is counted. The response is neither lost nor early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted when both high |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_src | input | $clog2(NPROC) | Requesting processor |
| req_blk | input | $clog2(NBLK) | Block index |
| msg_valid | output | 1 | Coherence message issued this cycle |
| msg_type | output | 2 | 0 invalidate, 1 downgrade, 2 take-away |
| msg_dst | output | $clog2(NPROC) | Target processor |
| ack_valid | input | 1 | One acknowledgement for an issued message |
| rsp_valid | output | 1 | One-cycle completion to the requester |
| rsp_dst | output | $clog2(NPROC) | Requester receiving the response |
| rsp_err | output | 1 | Protocol error flag |
| rsp_state | output | 2 | Resulting state: 0 uncached, 1 shared, 2 exclusive |
| rsp_sharers | output | NPROC | Resulting presence vector |

## Verification
Two things can happen in the same cycle: the controller issues an invalidate, and an acknowledgement for an earlier message arrives. The bench provokes this in two ways. In one mode it acknowledges every message in the very cycle it appears, so that issue and acknowledgement coincide across a run of several invalidates. In the other it holds all acknowledgements back and releases them only after the last message. In both modes the bench counts the acknowledgements it still owes. It judges the response early if that count is not zero, and lost if the response never comes.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;
  typedef enum logic [1:0] {DIR_UNC = 2'd0, DIR_SHR = 2'd1, DIR_EXC = 2'd2} dir_state_e;
  typedef enum logic [1:0] {REQ_RD = 2'd0, REQ_WR = 2'd1, REQ_WB = 2'd2} req_kind_e;
  typedef enum logic [1:0] {MSG_INV = 2'd0, MSG_DWN = 2'd1, MSG_TAKE = 2'd2} msg_kind_e;
  typedef enum logic [1:0] {CT_IDLE = 2'd0, CT_BUSY = 2'd1, CT_REPLY = 2'd2} ctl_state_e;
endpackage

// File: rtl/dir_entry_array.sv
module dir_entry_array
  import coh_dir_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NBLK  = 8,
  localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BW-1:0]    rd_idx,
  output dir_state_e       rd_state,
  output logic [NPROC-1:0] rd_pres,
  input  logic             wr_en,
  input  logic [BW-1:0]    wr_idx,
  input  dir_state_e       wr_state,
  input  logic [NPROC-1:0] wr_pres
);
  dir_state_e       st_q   [NBLK];
  logic [NPROC-1:0] pres_q [NBLK];

  for (genvar g = 0; g < NBLK; g++) begin : g_ent
    logic ent_we;
    assign ent_we = wr_en && (wr_idx == BW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[g]   <= DIR_UNC;
        pres_q[g] <= '0;
      end else if (ent_we) begin
        st_q[g]   <= wr_state;
        pres_q[g] <= wr_pres;
      end
    end
  end

  assign rd_state = st_q[rd_idx];
  assign rd_pres  = pres_q[rd_idx];
endmodule

// File: rtl/dir_next_entry.sv
module dir_next_entry
  import coh_dir_pkg::*;
#(
  parameter int NPROC = 4,
  localparam int PW = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  req_kind_e        kind,
  input  logic [PW-1:0]    src,
  input  dir_state_e       cur_state,
  input  logic [NPROC-1:0] cur_pres,
  output logic             err,
  output dir_state_e       nxt_state,
  output logic [NPROC-1:0] nxt_pres,
  output logic [NPROC-1:0] tgt_mask,
  output msg_kind_e        tgt_kind
);
  logic [NPROC-1:0] src_oh;
  logic             have;

  assign src_oh = NPROC'(1) << src;
  assign have   = |(cur_pres & src_oh);

  always_comb begin
    err       = 1'b0;
    nxt_state = cur_state;
    nxt_pres  = cur_pres;
    tgt_mask  = '0;
    tgt_kind  = MSG_INV;
    unique case (kind)
      REQ_RD: begin
        if (have) begin
          err = 1'b1;
        end else begin
          nxt_state = DIR_SHR;
          nxt_pres  = cur_pres | src_oh;
          if (cur_state == DIR_EXC) begin
            tgt_mask = cur_pres;
            tgt_kind = MSG_DWN;
          end
        end
      end
      REQ_WR: begin
        if (have) begin
          err = 1'b1;
        end else begin
          nxt_state = DIR_EXC;
          nxt_pres  = src_oh;
          tgt_mask  = cur_pres;
          tgt_kind  = (cur_state == DIR_EXC) ? MSG_TAKE : MSG_INV;
        end
      end
      REQ_WB: begin
        if (!have || cur_state != DIR_EXC) begin
          err = 1'b1;
        end else begin
          nxt_state = DIR_UNC;
          nxt_pres  = '0;
        end
      end
      default: err = 1'b1;
    endcase
  end
endmodule

// File: rtl/dir_msg_sequencer.sv
module dir_msg_sequencer #(
  parameter int NPROC = 4,
  localparam int PW = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int CW = $clog2(NPROC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NPROC-1:0] load_mask,
  input  logic             run,
  input  logic             ack_valid,
  output logic             send,
  output logic [PW-1:0]    send_dst,
  output logic             all_done,
  output logic [CW-1:0]    outstanding
);
  logic [NPROC-1:0] pend_q, pend_d;
  logic [CW-1:0]    outst_q, outst_d;
  logic             pend_en, outst_en, ack_use;

  always_comb begin
    send_dst = '0;
    for (int i = NPROC - 1; i >= 0; i--) begin
      if (pend_q[i]) send_dst = PW'(i);
    end
  end

  assign send    = run && (|pend_q);
  assign ack_use = ack_valid && ((outst_q != '0) || send);

  always_comb begin
    pend_en  = load || send;
    pend_d   = load ? load_mask : (pend_q & ~(NPROC'(1) << send_dst));
    outst_en = load || send || ack_use;
    if (load) outst_d = '0;
    else      outst_d = outst_q + CW'(send) - CW'(ack_use);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        outst_q <= '0;
    else if (outst_en) outst_q <= outst_d;
  end

  assign all_done    = (pend_q == '0) && (outst_q == '0);
  assign outstanding = outst_q;
endmodule

// File: rtl/coh_dir_ctrl.sv
module coh_dir_ctrl
  import coh_dir_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NBLK  = 8,
  localparam int PW = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int CW = $clog2(NPROC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_kind,
  input  logic [PW-1:0]    req_src,
  input  logic [BW-1:0]    req_blk,
  output logic             msg_valid,
  output logic [1:0]       msg_type,
  output logic [PW-1:0]    msg_dst,
  input  logic             ack_valid,
  output logic             rsp_valid,
  output logic [PW-1:0]    rsp_dst,
  output logic             rsp_err,
  output logic [1:0]       rsp_state,
  output logic [NPROC-1:0] rsp_sharers
);
  ctl_state_e       st_q, st_d;
  logic             accept;
  dir_state_e       cur_state, nx_state;
  logic [NPROC-1:0] cur_pres, nx_pres, nx_tgt;
  logic             nx_err;
  msg_kind_e        nx_kind;
  logic             seq_done;
  logic [CW-1:0]    seq_outst;

  logic [PW-1:0]    src_q;
  logic [BW-1:0]    blk_q;
  logic             err_q;
  dir_state_e       new_state_q;
  logic [NPROC-1:0] new_pres_q;
  msg_kind_e        kind_q;

  assign req_ready = (st_q == CT_IDLE);
  assign accept    = req_valid && req_ready;

  dir_entry_array #(.NPROC(NPROC), .NBLK(NBLK)) u_arr (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (req_blk),
    .rd_state (cur_state),
    .rd_pres  (cur_pres),
    .wr_en    ((st_q == CT_REPLY) && !err_q),
    .wr_idx   (blk_q),
    .wr_state (new_state_q),
    .wr_pres  (new_pres_q)
  );

  dir_next_entry #(.NPROC(NPROC)) u_nx (
    .kind      (req_kind_e'(req_kind)),
    .src       (req_src),
    .cur_state (cur_state),
    .cur_pres  (cur_pres),
    .err       (nx_err),
    .nxt_state (nx_state),
    .nxt_pres  (nx_pres),
    .tgt_mask  (nx_tgt),
    .tgt_kind  (nx_kind)
  );

  dir_msg_sequencer #(.NPROC(NPROC)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (accept),
    .load_mask   (nx_err ? '0 : nx_tgt),
    .run         (st_q == CT_BUSY),
    .ack_valid   (ack_valid),
    .send        (msg_valid),
    .send_dst    (msg_dst),
    .all_done    (seq_done),
    .outstanding (seq_outst)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      CT_IDLE:  if (accept) st_d = CT_BUSY;
      CT_BUSY:  if (seq_done) st_d = CT_REPLY;
      CT_REPLY: st_d = CT_IDLE;
      default:  st_d = CT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= CT_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q       <= '0;
      blk_q       <= '0;
      err_q       <= 1'b0;
      new_state_q <= DIR_UNC;
      new_pres_q  <= '0;
      kind_q      <= MSG_INV;
    end else if (accept) begin
      src_q       <= req_src;
      blk_q       <= req_blk;
      err_q       <= nx_err;
      new_state_q <= nx_state;
      new_pres_q  <= nx_pres;
      kind_q      <= nx_kind;
    end
  end

  assign msg_type    = kind_q;
  assign rsp_valid   = (st_q == CT_REPLY);
  assign rsp_dst     = src_q;
  assign rsp_err     = err_q;
  assign rsp_state   = new_state_q;
  assign rsp_sharers = new_pres_q;
endmodule

// File: rtl/coh_dir_ctrl_chk.sv
module coh_dir_ctrl_chk #(
  parameter int NPROC = 4,
  parameter int PW = 2,
  parameter int CW = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             msg_valid,
  input logic [1:0]       msg_type,
  input logic [PW-1:0]    msg_dst,
  input logic             rsp_valid,
  input logic [PW-1:0]    rsp_dst,
  input logic             rsp_err,
  input logic [1:0]       rsp_state,
  input logic [NPROC-1:0] rsp_sharers,
  input logic [CW-1:0]    outstanding
);
  // R5
  inv_ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && $past(msg_valid) |-> msg_dst > $past(msg_dst));
  // R6
  single_owner_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_type != 2'd0 |=> !msg_valid);
  // R10
  no_early_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> outstanding == '0 && !msg_valid);
  // R10
  reply_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R10
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  // R8
  uncached_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_state == 2'd0 |-> rsp_sharers == '0);
  // R7
  excl_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_err && rsp_state == 2'd2 |-> $countones(rsp_sharers) == 1 && rsp_sharers[rsp_dst]);
endmodule

bind coh_dir_ctrl coh_dir_ctrl_chk #(.NPROC(NPROC), .PW(PW), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .msg_valid   (msg_valid),
  .msg_type    (msg_type),
  .msg_dst     (msg_dst),
  .rsp_valid   (rsp_valid),
  .rsp_dst     (rsp_dst),
  .rsp_err     (rsp_err),
  .rsp_state   (rsp_state),
  .rsp_sharers (rsp_sharers),
  .outstanding (seq_outst)
);

// File: tb/tb_coh_dir_ctrl.sv
module tb_coh_dir_ctrl;
  localparam int NP = 4;
  localparam int NB = 8;

  logic          clk, rst_n;
  logic          req_valid, req_ready, ack_valid;
  logic [1:0]    req_kind;
  logic [1:0]    req_src;
  logic [2:0]    req_blk;
  logic          msg_valid, rsp_valid, rsp_err;
  logic [1:0]    msg_type, msg_dst, rsp_dst, rsp_state;
  logic [NP-1:0] rsp_sharers;

  int n_chk, n_fail;
  int m_st [NB];
  logic [NP-1:0] m_pr [NB];

  coh_dir_ctrl #(.NPROC(NP), .NBLK(NB)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_src(req_src), .req_blk(req_blk),
    .msg_valid(msg_valid), .msg_type(msg_type), .msg_dst(msg_dst),
    .ack_valid(ack_valid), .rsp_valid(rsp_valid), .rsp_dst(rsp_dst),
    .rsp_err(rsp_err), .rsp_state(rsp_state), .rsp_sharers(rsp_sharers)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  // kind: 0 read, 1 write, 2 write-back; late: hold acks until all messages issued
  task automatic run_req(input int k, input int s, input int b, input bit late);
    logic [NP-1:0] soh, tgt, npr;
    int nst, mt, owed, wait_c, cyc, lowest;
    bit err, got;
    string rq;
    soh = NP'(1) << s;
    err = 1'b0; tgt = '0; mt = 0; nst = m_st[b]; npr = m_pr[b];
    if (k == 2) begin
      if (m_st[b] == 2 && (m_pr[b] & soh) != 0) begin nst = 0; npr = '0; end
      else err = 1'b1;
    end else if ((m_pr[b] & soh) != 0) begin
      err = 1'b1;
    end else if (k == 0) begin
      nst = 1; npr = m_pr[b] | soh;
      if (m_st[b] == 2) begin tgt = m_pr[b]; mt = 1; end
    end else begin
      nst = 2; npr = soh; tgt = m_pr[b];
      mt = (m_st[b] == 2) ? 2 : 0;
    end
    if (err) rq = "R9";
    else if (k == 2) rq = "R8";
    else if (k == 0) rq = (m_st[b] == 0) ? "R2" : (m_st[b] == 1) ? "R3" : "R6";
    else rq = (m_st[b] == 0) ? "R4" : (m_st[b] == 1) ? "R5" : "R7";

    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'(k); req_src = 2'(s); req_blk = 3'(b);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10", int'(req_ready), 0);
    owed = 0; wait_c = 0; cyc = 0; got = 1'b0;
    while (!got && cyc < 100) begin
      ack_valid = 1'b0;
      if (rsp_valid) begin
        got = 1'b1;
        chk(owed == 0 && tgt == '0, late ? "R10" : "R11", owed, 0);
        chk(rsp_dst == 2'(s), "R10", int'(rsp_dst), s);
        chk(rsp_err == err, rq, int'(rsp_err), int'(err));
        chk(int'(rsp_state) == nst, rq, int'(rsp_state), nst);
        chk(rsp_sharers == npr, rq, int'(rsp_sharers), int'(npr));
      end else if (msg_valid) begin
        lowest = -1;
        for (int i = NP - 1; i >= 0; i--) if (tgt[i]) lowest = i;
        chk(int'(msg_dst) == lowest, rq, int'(msg_dst), lowest);
        chk(int'(msg_type) == mt, rq, int'(msg_type), mt);
        if (lowest >= 0) tgt[lowest] = 1'b0;
        if (late) owed++;
        else ack_valid = 1'b1;
      end else if (late && owed > 0 && tgt == '0) begin
        wait_c++;
        if (wait_c > 2) begin ack_valid = 1'b1; owed--; end
      end
      if (!got) begin @(negedge clk); cyc++; end
    end
    ack_valid = 1'b0;
    chk(got, "R10", int'(got), 1);
    if (!err) begin m_st[b] = nst; m_pr[b] = npr; end
  endtask

  initial begin
    logic [15:0] lf;
    n_chk = 0; n_fail = 0;
    req_valid = 1'b0; req_kind = '0; req_src = '0; req_blk = '0; ack_valid = 1'b0;
    for (int i = 0; i < NB; i++) begin m_st[i] = 0; m_pr[i] = '0; end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", int'(req_ready), 1);
    chk(msg_valid == 1'b0 && rsp_valid == 1'b0, "R1", int'(msg_valid | rsp_valid), 0);
    // R1: every block behaves as uncached: write-back is refused
    for (int b = 0; b < NB; b++) run_req(2, b % NP, b, 1'b0);
    // R2 R3 R5 with three sharers, acks coincide with issue (R11)
    run_req(0, 0, 1, 1'b0);
    run_req(0, 1, 1, 1'b0);
    run_req(0, 3, 1, 1'b0);
    run_req(1, 2, 1, 1'b0);
    // R6 then R5 with late acks
    run_req(0, 0, 1, 1'b1);
    run_req(1, 1, 1, 1'b1);
    // R7, R9 on upgrade, R8
    run_req(1, 3, 1, 1'b0);
    run_req(0, 3, 1, 1'b0);
    run_req(2, 3, 1, 1'b0);
    run_req(1, 0, 2, 1'b1);
    run_req(2, 0, 2, 1'b1);
    // pseudo-random sweep
    lf = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      run_req((lf[3:2] == 2'd3) ? 0 : int'(lf[3:2]), int'(lf[5:4]), int'(lf[8:6]) % 4, lf[9]);
    end
    finish_run();
  end
endmodule